// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block remembers the stores that have gone into the current dispatch group and tells a scheduler, in the same cycle, whether a candidate load could read bytes that one of those stores writes. The scheduler can then keep the load out of the group. Every address is written as two operands: a first operand that acts as an offset and a second operand that acts as a base. Each operand is either a symbolic tag or a constant. The operand carries a flag bit that says which kind it is, plus a value field.

Matching is symbolic. Two operands are equal only when both the flag and the value agree. A load matches a store when its two operands equal the store's two operands, either in the same order or exchanged. If neither holds, the block still reports a match when the bases are equal, both offsets are constants and the two byte ranges intersect. The table is filled by a record strobe and emptied by a group-clear strobe. The query path is purely combinational.

Top module: `ovl_detect`

## Requirements
- R1: The 3-bit size code gives the access width in bytes. Codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 are treated as 16 bytes.
- R2: A valid load whose first and second operands equal a tracked store's first and second operands raises `hit`. Equality covers both the constant flag and the value.
- R3: A valid load whose first operand equals a tracked store's second operand, and whose second operand equals that store's first operand, raises `hit`.
- R4: The range rule applies when a load and a tracked store have equal second operands and both first operands are constants (flag bit set). With store offset S, store size SS, load offset L and load size LS: `hit` is raised when S < L and S+SS > L, or when S >= L and L+LS > S. The sums are taken without wrap.
- R5: When neither R2 nor R3 holds, no `hit` is produced if the second operands differ or either first operand is a tag.
- R6: A record strobe with the table not full stores the operands and size in the next free slot, and `st_cnt` rises by one on the next clock edge. Every stored entry takes part in later queries.
- R7: The group-clear strobe sets `st_cnt` to 0 and clears `overflow` on the next edge. It wins over a record strobe in the same cycle, and that store is not kept.
- R8: The table holds ENTRIES stores (4 by default). A record strobe while full leaves `st_cnt` and the table unchanged and sets `overflow`. `overflow` stays set until a group clear or reset.
- R9: `hit` is the OR of the comparisons over the first `st_cnt` entries only. Slots left over from an earlier group never match, and `hit` is 0 while `ld_vld` is low.
- R10: A synchronous active-low reset leaves `st_cnt` at 0 and `overflow` at 0, so `hit` is 0 for any query.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| st_rec | input | 1 | Record the store presented on the st_* operands |
| st_op1 | input | VAL_W+1 | Store first operand: bit VAL_W is the constant flag, the low bits are the tag or value |
| st_op2 | input | VAL_W+1 | Store second (base) operand, same layout |
| st_size | input | 3 | Store size code (R1) |
| grp_clr | input | 1 | End of dispatch group: empty the table |
| ld_vld | input | 1 | A load query is present |
| ld_op1 | input | VAL_W+1 | Load first operand, same layout |
| ld_op2 | input | VAL_W+1 | Load second (base) operand, same layout |
| ld_size | input | 3 | Load size code (R1) |
| hit | output | 1 | The load may touch bytes of a tracked store |
| st_cnt | output | $clog2(ENTRIES+1) | Number of stores tracked |
| overflow | output | 1 | A record strobe arrived while the table was full |

## Verification
The hardest case to reach from the ports is the boundary of the range rule. One byte either way decides between a hit and a miss, and the two branches of the rule switch at equal offsets. The stimulus therefore records a single store for every constant offset in a small window and every size code, including the codes that clamp to 16 bytes. Against each such store it sweeps every load offset and size in the same window, and compares the result with an interval-intersection formula computed in the bench. Stale slots also need care: they can only be exposed by filling the table, clearing it and then refilling it only in part. The bench does exactly that and queries the old contents.

// File: rtl/ovl_pkg.sv
// Package ovl_pkg
// Shared constants and the size decoder used by the overlap detector.
// Assumes size codes are 3 bits wide and that the widest access is 16 bytes.
package ovl_pkg;
    localparam int SZ_W    = 3;   // width of a size code
    localparam int BYTES_W = 5;   // enough bits to hold 16

    // Turn a size code into a byte count; codes above 4 clamp to 16 bytes.
    function automatic logic [BYTES_W-1:0] size_bytes(input logic [SZ_W-1:0] code);
        logic [BYTES_W-1:0] b;
        case (code)
            3'd0:    b = 5'd1;
            3'd1:    b = 5'd2;
            3'd2:    b = 5'd4;
            3'd3:    b = 5'd8;
            default: b = 5'd16;
        endcase
        return b;
    endfunction
endpackage

// File: rtl/ovl_entry_cmp.sv
// Module ovl_entry_cmp
// Compares one tracked store against the load query and flags a possible overlap.
// Assumes operand bit VAL_W is the constant flag and the low VAL_W bits are the tag or value.
// Contains no state; the result is valid in the same cycle as its inputs.
module ovl_entry_cmp
    import ovl_pkg::*;
#(
    parameter int VAL_W = 8,
    localparam int OP_W  = VAL_W + 1,
    localparam int SUM_W = VAL_W + BYTES_W
) (
    input  logic            ent_vld,
    input  logic [OP_W-1:0] s_op1,
    input  logic [OP_W-1:0] s_op2,
    input  logic [SZ_W-1:0] s_size,
    input  logic [OP_W-1:0] l_op1,
    input  logic [OP_W-1:0] l_op2,
    input  logic [SZ_W-1:0] l_size,
    output logic            match
);
    logic             same_order;
    logic             swapped;
    logic             offs_rule;
    logic [SUM_W-1:0] s_ofs;
    logic [SUM_W-1:0] l_ofs;
    logic [SUM_W-1:0] s_end;
    logic [SUM_W-1:0] l_end;
    logic             ranges_meet;

    // Symbolic checks: operands equal in the same order or exchanged.
    always_comb begin
        same_order = (l_op1 == s_op1) && (l_op2 == s_op2);
        swapped    = (l_op1 == s_op2) && (l_op2 == s_op1);
        offs_rule  = (l_op2 == s_op2) && s_op1[VAL_W] && l_op1[VAL_W];
    end

    // Byte-range test on constant offsets, computed wide enough not to wrap.
    always_comb begin
        s_ofs = SUM_W'(s_op1[VAL_W-1:0]);
        l_ofs = SUM_W'(l_op1[VAL_W-1:0]);
        s_end = s_ofs + SUM_W'(size_bytes(s_size));
        l_end = l_ofs + SUM_W'(size_bytes(l_size));
        if (s_ofs < l_ofs) ranges_meet = (s_end > l_ofs);
        else               ranges_meet = (l_end > s_ofs);
    end

    // Combine the three tests; an invalid slot never matches.
    always_comb begin
        match = ent_vld && (same_order || swapped || (offs_rule && ranges_meet));
    end
endmodule

// File: rtl/ovl_store_table.sv
// Module ovl_store_table
// Holds the stores recorded in the current dispatch group, appended in arrival order.
// Assumes a clear in the same cycle as a record wins, and a record while full is dropped
// and latched as a sticky overflow. Reset is synchronous and active low.
module ovl_store_table
    import ovl_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VAL_W   = 8,
    localparam int OP_W   = VAL_W + 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_i,
    input  logic [OP_W-1:0]  op1_i,
    input  logic [OP_W-1:0]  op2_i,
    input  logic [SZ_W-1:0]  size_i,
    input  logic             clr_i,
    output logic [OP_W-1:0]  ent_op1 [ENTRIES],
    output logic [OP_W-1:0]  ent_op2 [ENTRIES],
    output logic [SZ_W-1:0]  ent_size[ENTRIES],
    output logic [ENTRIES-1:0] ent_vld,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic             full;
    logic             do_append;

    // Decide whether this cycle's record strobe is accepted.
    always_comb begin
        full      = (cnt_q == CNT_W'(ENTRIES));
        do_append = rec_i && !clr_i && !full;
    end

    // Occupancy counter and sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr_i) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else if (rec_i) begin
            if (full) ovf_q <= 1'b1;
            else      cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
        // Capture the store into the slot addressed by the current count.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_op1[i]  <= '0;
                ent_op2[i]  <= '0;
                ent_size[i] <= '0;
            end else if (do_append && (cnt_q == CNT_W'(i))) begin
                ent_op1[i]  <= op1_i;
                ent_op2[i]  <= op2_i;
                ent_size[i] <= size_i;
            end
        end

        // A slot counts as live only below the occupancy count.
        always_comb begin
            ent_vld[i] = (CNT_W'(i) < cnt_q);
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    // R8: occupancy never exceeds the table depth.
    p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(ENTRIES));

    // R6: an accepted record grows the count by exactly one.
    p_append_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_i && !clr_i && cnt_q != CNT_W'(ENTRIES)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    // R7: a clear empties the table and drops the overflow flag.
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cnt_q == '0 && !ovf_q));

    // R8: a record into a full table leaves the count alone and raises overflow.
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_i && !clr_i && cnt_q == CNT_W'(ENTRIES)) |=> (ovf_q && $stable(cnt_q)));

    // R8: overflow stays set until a clear.
    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr_i) |=> ovf_q);
endmodule

// File: rtl/ovl_detect.sv
// Module ovl_detect
// Top level of the in-group store-load overlap detector: a store table plus one
// comparator per slot, with the per-slot results ORed into a single hit.
// Assumes the scheduler pulses grp_clr at every dispatch-group boundary.
module ovl_detect
    import ovl_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int VAL_W   = 8,
    localparam int OP_W   = VAL_W + 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_rec,
    input  logic [OP_W-1:0]  st_op1,
    input  logic [OP_W-1:0]  st_op2,
    input  logic [SZ_W-1:0]  st_size,
    input  logic             grp_clr,
    input  logic             ld_vld,
    input  logic [OP_W-1:0]  ld_op1,
    input  logic [OP_W-1:0]  ld_op2,
    input  logic [SZ_W-1:0]  ld_size,
    output logic             hit,
    output logic [CNT_W-1:0] st_cnt,
    output logic             overflow
);
    logic [OP_W-1:0]    tbl_op1 [ENTRIES];
    logic [OP_W-1:0]    tbl_op2 [ENTRIES];
    logic [SZ_W-1:0]    tbl_size[ENTRIES];
    logic [ENTRIES-1:0] tbl_vld;
    logic [ENTRIES-1:0] slot_hit;

    ovl_store_table #(.ENTRIES(ENTRIES), .VAL_W(VAL_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rec_i    (st_rec),
        .op1_i    (st_op1),
        .op2_i    (st_op2),
        .size_i   (st_size),
        .clr_i    (grp_clr),
        .ent_op1  (tbl_op1),
        .ent_op2  (tbl_op2),
        .ent_size (tbl_size),
        .ent_vld  (tbl_vld),
        .cnt_o    (st_cnt),
        .ovf_o    (overflow)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        ovl_entry_cmp #(.VAL_W(VAL_W)) u_cmp (
            .ent_vld (tbl_vld[i]),
            .s_op1   (tbl_op1[i]),
            .s_op2   (tbl_op2[i]),
            .s_size  (tbl_size[i]),
            .l_op1   (ld_op1),
            .l_op2   (ld_op2),
            .l_size  (ld_size),
            .match   (slot_hit[i])
        );
    end

    // Reduce per-slot results and gate with the query valid.
    always_comb begin
        hit = ld_vld && (|slot_hit);
    end

    // R9: no hit without a query or with an empty table.
    p_hit_needs_entry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (ld_vld && st_cnt != '0));

    // R9: slot validity is a contiguous run from slot 0.
    p_vld_contig_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(tbl_vld) == int'(st_cnt));
endmodule

// File: tb/ovl_detect_tb.sv
// Bench ovl_detect_tb_top
// Sweeps the range rule over every size code and a window of constant offsets,
// then walks the symbolic, capacity and clear cases; expected values are computed here.
module ovl_detect_tb_top;
    localparam int ENTRIES = 4;
    localparam int VAL_W   = 8;
    localparam int OP_W    = VAL_W + 1;
    localparam int CNT_W   = $clog2(ENTRIES + 1);
    localparam int WIN     = 24;
    localparam logic [VAL_W-1:0] BASE = 8'd7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             st_rec;
    logic [OP_W-1:0]  st_op1, st_op2;
    logic [2:0]       st_size;
    logic             grp_clr;
    logic             ld_vld;
    logic [OP_W-1:0]  ld_op1, ld_op2;
    logic [2:0]       ld_size;
    logic             hit;
    logic [CNT_W-1:0] st_cnt;
    logic             overflow;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    ovl_detect #(.ENTRIES(ENTRIES), .VAL_W(VAL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .st_rec(st_rec), .st_op1(st_op1), .st_op2(st_op2),
        .st_size(st_size), .grp_clr(grp_clr), .ld_vld(ld_vld), .ld_op1(ld_op1),
        .ld_op2(ld_op2), .ld_size(ld_size), .hit(hit), .st_cnt(st_cnt), .overflow(overflow)
    );

    function automatic int nbytes(input int code);
        return (code >= 4) ? 16 : (1 << code);
    endfunction

    function automatic logic [OP_W-1:0] opnd(input bit is_const, input int v);
        return {is_const, VAL_W'(v)};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic rec(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input int sz);
        @(negedge clk);
        st_rec = 1'b1; st_op1 = a; st_op2 = b; st_size = 3'(sz);
        @(negedge clk);
        st_rec = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk);
        grp_clr = 1'b1;
        @(negedge clk);
        grp_clr = 1'b0;
    endtask

    task automatic query(input logic [OP_W-1:0] a, input logic [OP_W-1:0] b, input int sz);
        ld_vld = 1'b1; ld_op1 = a; ld_op2 = b; ld_size = 3'(sz);
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        rst_n = 1'b0; st_rec = 1'b0; grp_clr = 1'b0; ld_vld = 1'b0;
        st_op1 = '0; st_op2 = '0; st_size = '0; ld_op1 = '0; ld_op2 = '0; ld_size = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        query(opnd(0, 0), opnd(0, 0), 0);
        check("R10 cnt", int'(st_cnt), 0);
        check("R10 ovf", int'(overflow), 0);
        check("R10 hit", int'(hit), 0);

        // R4 and R1: exhaustive offset/size sweep against one constant-offset store
        for (int sc = 0; sc < 8; sc++) begin
            for (int so = 0; so < WIN; so++) begin
                clr();
                rec(opnd(1, so), {1'b0, BASE}, sc);
                for (int lc = 0; lc < 8; lc++) begin
                    for (int lo = 0; lo < WIN; lo++) begin
                        int lo_max, hi_min, exp;
                        query(opnd(1, lo), {1'b0, BASE}, lc);
                        lo_max = (so > lo) ? so : lo;
                        hi_min = (so + nbytes(sc) < lo + nbytes(lc)) ? so + nbytes(sc) : lo + nbytes(lc);
                        exp = (lo_max < hi_min) ? 1 : 0;
                        check("R4/R1 range", int'(hit), exp);
                    end
                end
            end
        end

        // R2, R3, R5: symbolic matching with tag operands
        clr();
        rec(opnd(0, 3), opnd(0, 9), 2);
        query(opnd(0, 3), opnd(0, 9), 0);  check("R2 same order", int'(hit), 1);
        query(opnd(0, 9), opnd(0, 3), 3);  check("R3 swapped", int'(hit), 1);
        query(opnd(0, 3), opnd(0, 10), 2); check("R5 base differs", int'(hit), 0);
        query(opnd(1, 3), opnd(0, 9), 2);  check("R5 flag differs", int'(hit), 0);
        query(opnd(0, 4), opnd(0, 9), 2);  check("R5 tag offset", int'(hit), 0);
        clr();
        rec(opnd(1, 5), opnd(0, 9), 0);
        query(opnd(0, 9), opnd(1, 5), 0);  check("R3 swapped const", int'(hit), 1);
        query(opnd(1, 5), opnd(0, 10), 4); check("R5 const base differs", int'(hit), 0);
        clr();
        rec(opnd(0, 5), opnd(0, 9), 4);
        query(opnd(1, 5), opnd(0, 9), 4);  check("R5 store tag offset", int'(hit), 0);

        // R6, R8: fill the table, then overflow
        clr();
        for (int k = 0; k < ENTRIES; k++) begin
            rec(opnd(0, 20 + k), opnd(0, 40 + k), 1);
            check("R6 count", int'(st_cnt), k + 1);
        end
        for (int k = 0; k < ENTRIES; k++) begin
            query(opnd(0, 20 + k), opnd(0, 40 + k), 1);
            check("R6 entry visible", int'(hit), 1);
        end
        check("R8 no ovf yet", int'(overflow), 0);
        rec(opnd(0, 60), opnd(0, 61), 1);
        check("R8 cnt held", int'(st_cnt), ENTRIES);
        check("R8 ovf set", int'(overflow), 1);
        query(opnd(0, 60), opnd(0, 61), 1); check("R8 dropped store", int'(hit), 0);
        repeat (3) @(negedge clk);
        check("R8 ovf sticky", int'(overflow), 1);

        // R7: clear empties and drops overflow
        clr();
        check("R7 cnt", int'(st_cnt), 0);
        check("R7 ovf", int'(overflow), 0);
        query(opnd(0, 20), opnd(0, 40), 1); check("R7 no hit", int'(hit), 0);

        // R9: stale slots and ld_vld gating
        rec(opnd(0, 30), opnd(0, 31), 0);
        for (int k = 1; k < ENTRIES; k++) begin
            query(opnd(0, 20 + k), opnd(0, 40 + k), 1);
            check("R9 stale slot", int'(hit), 0);
        end
        query(opnd(0, 30), opnd(0, 31), 0); check("R9 live slot", int'(hit), 1);
        ld_vld = 1'b0; #1;
        check("R9 vld low", int'(hit), 0);

        // R7: clear wins over a simultaneous record
        @(negedge clk);
        grp_clr = 1'b1; st_rec = 1'b1; st_op1 = opnd(0, 50); st_op2 = opnd(0, 51); st_size = 3'd0;
        @(negedge clk);
        grp_clr = 1'b0; st_rec = 1'b0;
        check("R7 priority cnt", int'(st_cnt), 0);
        query(opnd(0, 50), opnd(0, 51), 0); check("R7 priority hit", int'(hit), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule